// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block turns single high-level requests into the byte transactions that a serial NOR flash expects. A requester presents an operation code, an address and a length for one cycle. The sequencer then drives a byte-level SPI engine one byte at a time and controls the flash select line itself. Each byte is started with a one-cycle strobe and completes when the engine returns a done strobe together with the byte it received. The sequencer supports seven operations: data read, identity read, status read, write enable, sector erase, full-array erase and single-page program.

For program and erase operations the sequencer first runs a separate write-enable transaction. It then runs the operation itself and afterwards keeps reading the status register until the flash reports it is idle. Only then does it signal completion. Read data is streamed out byte by byte. The identity word and the status byte are held on a result output. The select line always goes back high for a fixed number of clock cycles between transactions.

Top module: `flash_cmd_seq`

## Requirements
- R1: `cs_n` is 1 after reset and whenever `busy` is 0. Every `bx_start` strobe occurs while `cs_n` is 0, and each transaction is a single window in which `cs_n` is low.
- R2: Operation codes on `req_op` are 0 data read, 1 identity read, 2 status read, 3 write enable, 4 sector erase, 5 full erase and 6 page program. The first byte of the main transaction is 0x03, 0x90, 0x05, 0x06, 0x20, 0xC7 and 0x02 respectively.
- R3: Data read, page program and sector erase send three address bytes after the opcode, most significant first. For sector erase the address sent is `req_addr[11:0]` (the sector index) multiplied by 4096.
- R4: Identity read sends 0x90, 0x00, 0x00, 0x00 and then two dummy bytes. `res_word` then holds {first received byte, second received byte}.
- R5: Every byte clocked in for a read is sent as 0xFF. A data read of `req_len` bytes (1 to 2^LEN_W-1) gives exactly `req_len` `rd_valid` pulses, all inside one select window. The `rd_data` values are the bytes received in order. No other operation pulses `rd_valid`.
- R6: Page program sends `req_len` bytes from `wr_data` after the address. It pulses `wr_take` once per byte, in the cycle that byte is started, and the requester then presents the next byte.
- R7: Page program and both erase operations are preceded by a separate transaction that consists of the single byte 0x06.
- R8: After program or erase, the sequencer repeats a two-byte transaction (0x05 followed by a dummy byte) until the received status has bit 0 equal to 0.
- R9: `cs_n` stays high for at least GAP_CYC clock cycles between any two transactions, and before `done`.
- R10: `busy` is 1 from the cycle after a request is accepted until the cycle after `done`. `done` is a single-cycle pulse. Requests made while busy are ignored, and so is operation code 7.
- R11: Status read sends 0x05 and one dummy byte. `res_word` then holds {0x00, received status}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 24 | Byte address, or the sector index in bits 11:0 for sector erase |
| req_len | input | LEN_W | Byte count for data read and page program |
| wr_data | input | 8 | Current program byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_take | output | 1 | Program byte consumed |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| res_word | output | 16 | Identity word or status byte |
| cs_n | output | 1 | Flash select, active low |
| bx_start | output | 1 | Start one byte exchange |
| bx_tx | output | 8 | Byte to transmit |
| bx_done | input | 1 | Byte exchange finished |
| bx_rx | input | 8 | Byte received |

## Verification
The bench builds the block with LEN_W=16, GAP_CYC=3 and SECT_SHIFT=12. With a 16-bit length, a 300-byte read fits in one select window and crosses a 256-byte boundary, and a full 256-byte page can be programmed. GAP_CYC=3 makes the counter-based select gap visible as several cycles rather than one. A sector index of 0xFFF exercises the top of the 24-bit shifted address. The flash model reports busy for a random number of status reads (zero to three), so both a single poll and repeated polling are reached.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [2:0] {
      OP_READ   = 3'd0,
      OP_ID     = 3'd1,
      OP_STAT   = 3'd2,
      OP_WREN   = 3'd3,
      OP_SERASE = 3'd4,
      OP_CERASE = 3'd5,
      OP_PROG   = 3'd6,
      OP_NONE   = 3'd7
   } fcs_op_e;

   typedef enum logic [1:0] {
      FK_WREN,
      FK_MAIN,
      FK_POLL
   } fcs_frame_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT,
      ST_GAP,
      ST_DONE
   } fcs_state_e;

   localparam logic [7:0] CMD_WREN   = 8'h06;
   localparam logic [7:0] CMD_STAT   = 8'h05;
   localparam logic [7:0] CMD_READ   = 8'h03;
   localparam logic [7:0] CMD_PROG   = 8'h02;
   localparam logic [7:0] CMD_SERASE = 8'h20;
   localparam logic [7:0] CMD_CERASE = 8'hC7;
   localparam logic [7:0] CMD_ID     = 8'h90;
   localparam logic [7:0] DUMMY_BYTE = 8'hFF;

   // Operations that alter the array: need write enable first and busy polling after
   function automatic logic alters_array(input fcs_op_e op);
      return (op == OP_SERASE) || (op == OP_CERASE) || (op == OP_PROG);
   endfunction

endpackage

// File: rtl/fcs_frame_gen.sv
module fcs_frame_gen
   import fcs_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int SECT_SHIFT = 12
) (
   input  fcs_frame_e       fk,
   input  fcs_op_e          op,
   input  logic [LEN_W:0]   pos,
   input  logic [23:0]      addr,
   input  logic [LEN_W-1:0] len,
   input  logic [7:0]       wr_data,
   output logic [7:0]       tx_byte,
   output logic             in_data,
   output logic             frame_last
);

   localparam int PW = LEN_W + 1;

   logic [PW-1:0] hdr_n;
   logic [PW-1:0] dat_n;
   logic [PW-1:0] total;
   logic [7:0]    opc;
   logic [23:0]   eff;

   always_comb begin
      hdr_n = PW'(1);
      dat_n = '0;
      opc   = CMD_WREN;
      eff   = addr;
      case (fk)
         FK_WREN: opc = CMD_WREN;
         FK_POLL: begin
            opc   = CMD_STAT;
            dat_n = PW'(1);
         end
         default: begin
            case (op)
               OP_READ: begin
                  opc   = CMD_READ;
                  hdr_n = PW'(4);
                  dat_n = {1'b0, len};
               end
               OP_ID: begin
                  opc   = CMD_ID;
                  hdr_n = PW'(4);
                  dat_n = PW'(2);
                  eff   = '0;
               end
               OP_STAT: begin
                  opc   = CMD_STAT;
                  dat_n = PW'(1);
               end
               OP_SERASE: begin
                  opc   = CMD_SERASE;
                  hdr_n = PW'(4);
                  eff   = addr << SECT_SHIFT;
               end
               OP_CERASE: opc = CMD_CERASE;
               OP_PROG: begin
                  opc   = CMD_PROG;
                  hdr_n = PW'(4);
                  dat_n = {1'b0, len};
               end
               default: opc = CMD_WREN;
            endcase
         end
      endcase

      total      = hdr_n + dat_n;
      frame_last = (pos == total - PW'(1));
      in_data    = (pos >= hdr_n);

      if (!in_data) begin
         case (pos[1:0])
            2'd0:    tx_byte = opc;
            2'd1:    tx_byte = eff[23:16];
            2'd2:    tx_byte = eff[15:8];
            default: tx_byte = eff[7:0];
         endcase
      end else if (fk == FK_MAIN && op == OP_PROG) begin
         tx_byte = wr_data;
      end else begin
         tx_byte = DUMMY_BYTE;
      end
   end

endmodule

// File: rtl/fcs_gap_timer.sv
module fcs_gap_timer #(
   parameter int GAP_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(GAP_CYC - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= RELOAD;
      end else if (run && cnt != '0) begin
         cnt <= cnt - CW'(1);
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/fcs_capture.sv
module fcs_capture
   import fcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_ok,
   input  logic [7:0] rx,
   input  fcs_frame_e fk,
   input  fcs_op_e    op,
   input  logic       in_data,
   output logic       rd_valid,
   output logic [7:0] rd_data,
   output logic [15:0] res_word
);

   logic payload;
   assign payload = byte_ok && (fk == FK_MAIN) && in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         res_word <= '0;
      end else begin
         rd_valid <= payload && (op == OP_READ);
         if (payload && op == OP_READ) begin
            rd_data <= rx;
         end
         if (payload && op == OP_ID) begin
            res_word <= {res_word[7:0], rx};
         end else if (payload && op == OP_STAT) begin
            res_word <= {8'h00, rx};
         end
      end
   end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int LEN_W      = 16,
   parameter int GAP_CYC    = 3,
   parameter int SECT_SHIFT = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [23:0]      req_addr,
   input  logic [LEN_W-1:0] req_len,
   input  logic [7:0]       wr_data,
   output logic             busy,
   output logic             done,
   output logic             wr_take,
   output logic             rd_valid,
   output logic [7:0]       rd_data,
   output logic [15:0]      res_word,
   output logic             cs_n,
   output logic             bx_start,
   output logic [7:0]       bx_tx,
   input  logic             bx_done,
   input  logic [7:0]       bx_rx
);

   localparam int PW = LEN_W + 1;

   if (LEN_W < 9 || LEN_W > 24) begin : g_bad_len
      $error("LEN_W must allow a full page and stay within 24 bits");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("GAP_CYC must be at least one cycle");
   end
   if (SECT_SHIFT < 1 || SECT_SHIFT > 23) begin : g_bad_sect
      $error("SECT_SHIFT must fit inside a 24-bit address");
   end

   fcs_state_e       state;
   fcs_frame_e       fk;
   fcs_op_e          op_q;
   logic [23:0]      addr_q;
   logic [LEN_W-1:0] len_q;
   logic [PW-1:0]    pos;
   logic             cs_q;
   logic             poll_busy;

   logic             in_data;
   logic             frame_last;
   logic             gap_expired;
   logic             byte_ok;
   logic             frame_end;

   fcs_frame_gen #(
      .LEN_W      (LEN_W),
      .SECT_SHIFT (SECT_SHIFT)
   ) u_gen (
      .fk         (fk),
      .op         (op_q),
      .pos        (pos),
      .addr       (addr_q),
      .len        (len_q),
      .wr_data    (wr_data),
      .tx_byte    (bx_tx),
      .in_data    (in_data),
      .frame_last (frame_last)
   );

   assign byte_ok   = (state == ST_WAIT) && bx_done;
   assign frame_end = byte_ok && frame_last;

   fcs_gap_timer #(
      .GAP_CYC (GAP_CYC)
   ) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (frame_end),
      .run     (state == ST_GAP),
      .expired (gap_expired)
   );

   fcs_capture u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_ok  (byte_ok),
      .rx       (bx_rx),
      .fk       (fk),
      .op       (op_q),
      .in_data  (in_data),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .res_word (res_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         fk        <= FK_MAIN;
         op_q      <= OP_READ;
         addr_q    <= '0;
         len_q     <= '0;
         pos       <= '0;
         cs_q      <= 1'b1;
         poll_busy <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid && fcs_op_e'(req_op) != OP_NONE) begin
                  op_q   <= fcs_op_e'(req_op);
                  addr_q <= req_addr;
                  len_q  <= req_len;
                  fk     <= alters_array(fcs_op_e'(req_op)) ? FK_WREN : FK_MAIN;
                  pos    <= '0;
                  cs_q   <= 1'b0;
                  state  <= ST_SEND;
               end
            end
            ST_SEND: state <= ST_WAIT;
            ST_WAIT: begin
               if (bx_done) begin
                  if (fk == FK_POLL && in_data) begin
                     poll_busy <= bx_rx[0];
                  end
                  if (frame_last) begin
                     cs_q  <= 1'b1;
                     state <= ST_GAP;
                  end else begin
                     pos   <= pos + PW'(1);
                     state <= ST_SEND;
                  end
               end
            end
            ST_GAP: begin
               if (gap_expired) begin
                  if (fk == FK_WREN || (fk == FK_MAIN && alters_array(op_q)) ||
                      (fk == FK_POLL && poll_busy)) begin
                     fk    <= (fk == FK_WREN) ? FK_MAIN : FK_POLL;
                     pos   <= '0;
                     cs_q  <= 1'b0;
                     state <= ST_SEND;
                  end else begin
                     state <= ST_DONE;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign cs_n     = cs_q;
   assign busy     = (state != ST_IDLE);
   assign done     = (state == ST_DONE);
   assign bx_start = (state == ST_SEND);
   assign wr_take  = bx_start && (fk == FK_MAIN) && (op_q == OP_PROG) && in_data;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
   parameter int GAP_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic cs_n,
   input logic bx_start,
   input logic wr_take
);

   localparam int HW = $clog2(GAP_CYC + 2) + 1;
   localparam logic [HW-1:0] SAT = HW'(GAP_CYC + 1);

   // Consecutive cycles with the select line high, saturating; reset counts as a long idle
   logic [HW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= SAT;
      end else if (!cs_n) begin
         hi_cnt <= '0;
      end else if (hi_cnt != SAT) begin
         hi_cnt <= hi_cnt + HW'(1);
      end
   end

   p_start_in_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bx_start |-> !cs_n);

   p_idle_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CYC)));

   p_done_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && hi_cnt >= HW'(GAP_CYC)));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   p_take_with_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> bx_start);

   p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bx_start |=> !bx_start);

endmodule

bind flash_cmd_seq fcs_checker #(
   .GAP_CYC (GAP_CYC)
) u_fcs_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .cs_n     (cs_n),
   .bx_start (bx_start),
   .wr_take  (wr_take)
);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 16;
   localparam int GAP        = 3;
   localparam int LAT        = 4;
   localparam int WD_LIMIT   = 150000;
   localparam logic [7:0] ID_HI = 8'hC4;
   localparam logic [7:0] ID_LO = 8'h2B;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [2:0]       req_op = '0;
   logic [23:0]      req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0]       wr_data = '0;
   logic             busy, done, wr_take, rd_valid, cs_n, bx_start;
   logic [7:0]       rd_data, bx_tx;
   logic [15:0]      res_word;
   logic             bx_done = 1'b0;
   logic [7:0]       bx_rx = '0;

   flash_cmd_seq #(
      .LEN_W      (LEN_W),
      .GAP_CYC    (GAP),
      .SECT_SHIFT (12)
   ) u_flash_cmd_seq (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
      .req_addr (req_addr), .req_len (req_len), .wr_data (wr_data),
      .busy (busy), .done (done), .wr_take (wr_take), .rd_valid (rd_valid),
      .rd_data (rd_data), .res_word (res_word), .cs_n (cs_n),
      .bx_start (bx_start), .bx_tx (bx_tx), .bx_done (bx_done), .bx_rx (bx_rx)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int errors = 0;
   int checks = 0;

   // Flash and byte-engine model state
   int          cyc = 0;
   int          fcount, fpos, lat;
   logic [7:0]  fb [0:63][0:5];
   int          fn [0:63];
   logic [7:0]  cur_cmd = '0;
   logic [23:0] cur_addr = '0;
   logic [7:0]  resp = '0;
   int          busy_left = 0, busy_init = 0;
   logic [7:0]  stat_base = '0;
   int          rd_cnt, rd_bad, dummy_bad, prog_bad, take_cnt, gap_bad, done_cnt;
   int          gap_cnt = 1000;
   logic [23:0] rd_base = '0;
   logic [7:0]  pg_data [0:255];
   int          wr_idx = 0;
   logic        prev_cs = 1'b1;

   function automatic logic [7:0] rd_exp(input logic [23:0] a);
      return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
   endfunction

   function automatic logic [7:0] opc_of(input int op);
      case (op)
         0: return 8'h03;
         1: return 8'h90;
         2: return 8'h05;
         3: return 8'h06;
         4: return 8'h20;
         5: return 8'hC7;
         default: return 8'h02;
      endcase
   endfunction

   function automatic int len_of(input int op, input int len);
      case (op)
         0: return 4 + len;
         1: return 6;
         2: return 2;
         4: return 4;
         6: return 4 + len;
         default: return 1;
      endcase
   endfunction

   function automatic bit alters(input int op);
      return (op == 4) || (op == 5) || (op == 6);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
      bx_done = 1'b0;
      if (lat > 0) begin
         lat--;
         if (lat == 0) begin
            bx_done = 1'b1;
            bx_rx   = resp;
         end
      end
      if (cs_n && !prev_cs) begin
         if (fcount < 64) fn[fcount] = fpos;
         if (cur_cmd == 8'h02 || cur_cmd == 8'h20 || cur_cmd == 8'hC7) busy_left = busy_init;
         fcount++;
      end
      if (!cs_n && prev_cs) begin
         if (gap_cnt < GAP) gap_bad++;
         fpos = 0;
      end
      gap_cnt = cs_n ? gap_cnt + 1 : 0;
      if (done && gap_cnt < GAP) gap_bad++;
      if (bx_start) begin
         if (fpos == 0) cur_cmd = bx_tx;
         else if (fpos < 4) cur_addr = {cur_addr[15:0], bx_tx};
         if (fcount < 64 && fpos < 6) fb[fcount][fpos] = bx_tx;
         resp = 8'h00;
         if ((((cur_cmd == 8'h03) || (cur_cmd == 8'h90)) && fpos >= 4) ||
             (cur_cmd == 8'h05 && fpos == 1)) begin
            if (bx_tx !== 8'hFF) dummy_bad++;
         end
         if (cur_cmd == 8'h03 && fpos >= 4) resp = rd_exp(cur_addr + 24'(fpos - 4));
         if (cur_cmd == 8'h90 && fpos == 4) resp = ID_HI;
         if (cur_cmd == 8'h90 && fpos == 5) resp = ID_LO;
         if (cur_cmd == 8'h05 && fpos == 1) begin
            resp = {stat_base[7:1], (busy_left > 0)};
            if (busy_left > 0) busy_left--;
         end
         if (cur_cmd == 8'h02 && fpos >= 4) begin
            if (fpos - 4 > 255 || bx_tx !== pg_data[fpos - 4]) prog_bad++;
         end
         lat = LAT;
         fpos++;
      end
      if (rd_valid) begin
         if (rd_data !== rd_exp(rd_base + 24'(rd_cnt))) rd_bad++;
         rd_cnt++;
      end
      if (wr_take) begin
         take_cnt++;
         wr_idx++;
         wr_data = pg_data[wr_idx[7:0]];
      end
      if (done) done_cnt++;
      prev_cs = cs_n;
   end

   task automatic clear_logs();
      fcount = 0; rd_cnt = 0; rd_bad = 0; dummy_bad = 0; prog_bad = 0;
      take_cnt = 0; gap_bad = 0; done_cnt = 0; wr_idx = 0;
      for (int i = 0; i < 64; i++) fn[i] = 0;
   endtask

   task automatic run_op(input int op, input logic [23:0] addr, input int len, input bit inject);
      int k;
      clear_logs();
      rd_base = addr;
      wr_data = pg_data[0];
      @(negedge clk);
      req_valid = 1'b1;
      req_op    = 3'(op);
      req_addr  = addr;
      req_len   = LEN_W'(len);
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
      k = 0;
      while (done !== 1'b1) begin
         @(negedge clk);
         k++;
         if (inject && k == 10) begin
            req_valid = 1'b1;
            req_op    = 3'd0;
         end
         if (inject && k == 11) req_valid = 1'b0;
      end
      @(negedge clk);
      chk(busy === 1'b0, "R10 busy released after done", int'(busy), 0);
      chk(cs_n === 1'b1, "R1 deselected when idle", int'(cs_n), 1);
      repeat (4) @(negedge clk);
      chk(busy === 1'b0 && done_cnt == 1, "R10 single done, no late start", done_cnt, 1);
   endtask

   task automatic check_op(input int op, input logic [23:0] addr, input int len);
      int nw, npoll, m;
      logic [23:0] ea;
      nw    = alters(op) ? 1 : 0;
      npoll = alters(op) ? busy_init + 1 : 0;
      m     = nw;
      chk(fcount == nw + 1 + npoll, "R8 transaction count", fcount, nw + 1 + npoll);
      if (nw == 1) chk(fb[0][0] == 8'h06 && fn[0] == 1, "R7 separate write enable", int'(fb[0][0]), 6);
      chk(fb[m][0] == opc_of(op), "R2 opcode", int'(fb[m][0]), int'(opc_of(op)));
      chk(fn[m] == len_of(op, len), "R5 transaction length", fn[m], len_of(op, len));
      if (op == 0 || op == 4 || op == 6) begin
         ea = (op == 4) ? {addr[11:0], 12'h000} : addr;
         chk({fb[m][1], fb[m][2], fb[m][3]} == ea, "R3 address bytes",
             int'({fb[m][1], fb[m][2], fb[m][3]}), int'(ea));
      end
      if (op == 1) begin
         chk({fb[m][1], fb[m][2], fb[m][3]} == 24'h0, "R4 zero address",
             int'({fb[m][1], fb[m][2], fb[m][3]}), 0);
         chk(res_word == {ID_HI, ID_LO}, "R4 identity word", int'(res_word), int'({ID_HI, ID_LO}));
      end
      for (int i = 0; i < npoll; i++) begin
         chk(fb[m + 1 + i][0] == 8'h05 && fn[m + 1 + i] == 2, "R8 poll transaction",
             int'(fb[m + 1 + i][0]), 5);
      end
      if (op == 0) begin
         chk(rd_cnt == len, "R5 read byte count", rd_cnt, len);
         chk(rd_bad == 0, "R5 read data", rd_bad, 0);
      end else begin
         chk(rd_cnt == 0, "R5 no read strobe", rd_cnt, 0);
      end
      chk(dummy_bad == 0, "R5 dummy bytes", dummy_bad, 0);
      if (op == 2) chk(res_word == {8'h00, stat_base[7:1], 1'b0}, "R11 status result",
                       int'(res_word), int'({8'h00, stat_base[7:1], 1'b0}));
      if (op == 6) begin
         chk(prog_bad == 0, "R6 program bytes", prog_bad, 0);
         chk(take_cnt == len, "R6 take count", take_cnt, len);
      end
      chk(gap_bad == 0, "R9 select gap", gap_bad, 0);
   endtask

   task automatic fill_page();
      for (int i = 0; i < 256; i++) pg_data[i] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'h5EED_F1A5));
      fill_page();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n === 1'b1 && bx_start === 1'b0, "R1 reset deselect", int'(cs_n), 1);
      chk(busy === 1'b0 && done === 1'b0, "R10 reset idle", int'(busy), 0);

      // Directed corners
      busy_init = 0; stat_base = 8'hA5;
      run_op(0, 24'h012345, 1, 1'b0);          check_op(0, 24'h012345, 1);
      run_op(0, 24'hFFFFF0, 300, 1'b0);        check_op(0, 24'hFFFFF0, 300);
      fill_page();
      run_op(6, 24'h123400, 256, 1'b0);        check_op(6, 24'h123400, 256);
      busy_init = 2;
      run_op(4, 24'hABCFFF, 1, 1'b0);          check_op(4, 24'hABCFFF, 1);
      busy_init = 3;
      run_op(5, 24'h000000, 1, 1'b1);          check_op(5, 24'h000000, 1);
      run_op(1, 24'h777777, 1, 1'b0);          check_op(1, 24'h777777, 1);
      run_op(2, 24'h000000, 1, 1'b0);          check_op(2, 24'h000000, 1);
      run_op(3, 24'h000000, 1, 1'b0);          check_op(3, 24'h000000, 1);

      // Reserved code 7 is ignored
      clear_logs();
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd7;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (20) @(negedge clk);
      chk(busy === 1'b0 && fcount == 0 && done_cnt == 0, "R10 code 7 ignored", fcount, 0);
      chk(cs_n === 1'b1, "R1 no select on code 7", int'(cs_n), 1);

      // Constrained random operations
      for (int t = 0; t < 40; t++) begin
         int op, len;
         logic [23:0] addr;
         op        = int'($urandom_range(0, 6));
         addr      = 24'($urandom);
         len       = (op == 0) ? int'($urandom_range(1, 24)) :
                     (op == 6) ? int'($urandom_range(1, 16)) : 1;
         busy_init = int'($urandom_range(0, 3));
         stat_base = 8'($urandom);
         fill_page();
         run_op(op, addr, len, 1'b0);
         check_op(op, addr, len);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule